// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Arbiter

This block lets several peripheral stages share a single interrupt request line to a processor. Each stage keeps a pending flag that its device sets. The request line seen by the processor is the OR of all pending flags.

The processor answers with a one-cycle acknowledge pulse. That pulse enters the stage nearest the processor and moves down the chain. A stage with nothing pending passes the pulse on. A pending stage stops it, so no stage further down sees it. The stopping stage places its device code on a shared code bus, and the processor uses that code as the index of the handler to run. Position in the chain is therefore the priority, and no central encoder is involved.

If the pulse reaches the end of the chain without meeting a pending stage, the block drives no code and raises a spurious flag instead.

Top module: `irq_chain_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cpu_irq`, `code_valid` and `spurious` are low and `code_out` is zero.
- R2: A high `dev_req[i]` sets stage i's pending flag at the next clock edge. `cpu_irq` is high from that edge on while any stage is pending.
- R3: An acknowledge is taken by the pending stage with the lowest index. Stage 0 sits nearest the processor and has the highest priority.
- R4: The cycle after an acknowledge that meets a pending stage i, `code_valid` is high for that one cycle and `code_out` equals `BASE_CODE + i`.
- R5: Whenever `code_valid` is low, `code_out` is zero. Stages that are not granting drive zero onto the wired-OR code bus.
- R6: Only the granting stage clears its pending flag on the acknowledge edge. Every other pending stage stays pending and is granted by a later acknowledge.
- R7: An acknowledge with no stage pending raises `spurious` for exactly the next cycle. In that cycle `code_valid` is low and `code_out` is zero.
- R8: If a stage's `dev_req` is high in the same cycle that the stage is granted, the new request wins and the stage stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_req | input | N_STAGES | Per-stage request; bit 0 is the highest-priority stage |
| cpu_ack | input | 1 | Acknowledge pulse from the processor, one cycle per acknowledge |
| cpu_irq | output | 1 | Shared interrupt request line: the OR of all pending flags |
| code_valid | output | 1 | The code bus carries a granted device code this cycle |
| code_out | output | CODE_W | Device code of the granted stage, zero otherwise |
| spurious | output | 1 | The previous acknowledge found no pending stage |

## Verification
The tests start with a single request in the middle of the chain. This shows that the code value comes from the stage's position and not from a fixed slot. Next, every stage is loaded at once and acknowledged repeatedly. The codes must come out in ascending stage order, and one more acknowledge must then give the spurious flag. This separates correct blocking of the pulse, and correct clearing of only the winner, from designs that grant the wrong stage or clear too much.

A request raised in the same cycle as its own grant checks the set-over-clear rule. Acknowledges in consecutive cycles check that each pulse is resolved on its own. A final run uses random requests and a processor stub that acknowledges at random, and every cycle is compared against a behavioural model.

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter #(
  parameter int N_STAGES  = 4,
  parameter int CODE_W    = 8,
  parameter int BASE_CODE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STAGES-1:0] dev_req,
  input  logic                cpu_ack,
  output logic                cpu_irq,
  output logic                code_valid,
  output logic [CODE_W-1:0]   code_out,
  output logic                spurious
);

  logic [N_STAGES-1:0] pend;
  logic [N_STAGES-1:0] grant;
  logic [N_STAGES:0]   ack_chain;
  logic [CODE_W-1:0]   stage_code [N_STAGES];
  logic [CODE_W-1:0]   code_bus;

  assign ack_chain[0] = cpu_ack;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    assign grant[g]       = ack_chain[g] & pend[g];
    assign ack_chain[g+1] = ack_chain[g] & ~pend[g];
    assign stage_code[g]  = grant[g] ? CODE_W'(BASE_CODE + g) : '0;
  end

  always_comb begin
    code_bus = '0;
    for (int i = 0; i < N_STAGES; i++) code_bus = code_bus | stage_code[i];
  end

  assign cpu_irq = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      code_valid <= 1'b0;
      code_out   <= '0;
      spurious   <= 1'b0;
    end else begin
      pend       <= (pend & ~grant) | dev_req;
      code_valid <= |grant;
      code_out   <= code_bus;
      spurious   <= ack_chain[N_STAGES];
    end
  end

endmodule

module irq_chain_arbiter_chk #(
  parameter int N_STAGES  = 4,
  parameter int CODE_W    = 8,
  parameter int BASE_CODE = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_STAGES-1:0] dev_req,
  input logic                cpu_ack,
  input logic                cpu_irq,
  input logic                code_valid,
  input logic [CODE_W-1:0]   code_out,
  input logic                spurious,
  input logic [N_STAGES-1:0] pend
);

  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |-> code_out == '0); // R5

  AST_NO_DOUBLE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_valid && spurious)); // R7

  AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> (code_valid ^ spurious)); // R4

  AST_IDLE_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !cpu_irq |=> spurious && !code_valid); // R7

  AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_req) |=> cpu_irq); // R2

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq && !cpu_ack |=> cpu_irq); // R2

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (int'(code_out) >= BASE_CODE && int'(code_out) < BASE_CODE + N_STAGES)); // R4

  AST_HEAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && pend[0] |=> code_out == CODE_W'(BASE_CODE)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req[0] |=> pend[0]); // R8

endmodule

bind irq_chain_arbiter irq_chain_arbiter_chk #(
  .N_STAGES(N_STAGES), .CODE_W(CODE_W), .BASE_CODE(BASE_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_ack(cpu_ack),
  .cpu_irq(cpu_irq), .code_valid(code_valid), .code_out(code_out),
  .spurious(spurious), .pend(pend)
);

// File: tb/irq_chain_arbiter_tb.sv
`timescale 1ns/1ps
module irq_chain_arbiter_tb;
  localparam int N = 4;
  localparam int CW = 8;
  localparam int BASE = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] dev_req = '0;
  logic cpu_ack = 1'b0;
  logic cpu_irq, code_valid, spurious;
  logic [CW-1:0] code_out;

  int checks = 0;
  int errors = 0;

  bit [N-1:0] m_pend;
  bit e_irq, e_valid, e_spur;
  int e_code;

  always #2 clk = ~clk;

  irq_chain_arbiter #(.N_STAGES(N), .CODE_W(CW), .BASE_CODE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_ack(cpu_ack),
    .cpu_irq(cpu_irq), .code_valid(code_valid), .code_out(code_out),
    .spurious(spurious)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string ph);
    chk({ph, " R2 cpu_irq"}, int'(cpu_irq), int'(e_irq));
    chk({ph, " R4 code_valid"}, int'(code_valid), int'(e_valid));
    chk({ph, e_valid ? " R3 code_out" : " R5 code_out"}, int'(code_out), e_code);
    chk({ph, " R7 spurious"}, int'(spurious), int'(e_spur));
  endtask

  // model: drive at negedge, predict the state after the next rising edge, compare at the following negedge
  task automatic step(input logic [N-1:0] req, input logic ack, input string ph);
    int win;
    dev_req = req;
    cpu_ack = ack;
    win = -1;
    if (ack) begin
      for (int i = N - 1; i >= 0; i--) if (m_pend[i]) win = i;
    end
    e_valid = (win >= 0);
    e_code  = (win >= 0) ? BASE + win : 0;
    e_spur  = ack && (win < 0);
    if (win >= 0) m_pend[win] = 1'b0;
    m_pend = m_pend | req;
    e_irq = |m_pend;
    @(negedge clk);
    compare(ph);
  endtask

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pend = '0; e_irq = 0; e_valid = 0; e_spur = 0; e_code = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    step('0, 1'b0, "R1 first");

    // one request in mid-chain
    step(4'b0100, 1'b0, "R2 set");
    step('0, 1'b0, "R2 hold");
    step('0, 1'b1, "R3 single");
    step('0, 1'b0, "R4 after");

    // all stages pending, drained in priority order
    step(4'b1111, 1'b0, "R6 load");
    for (int k = 0; k < N; k++) step('0, 1'b1, "R6 drain");
    step('0, 1'b1, "R7 empty");
    step('0, 1'b0, "R7 idle");

    // request in the same cycle as its own grant
    step(4'b0010, 1'b0, "R8 set");
    step(4'b0010, 1'b1, "R8 collide");
    step('0, 1'b0, "R8 still");
    step('0, 1'b1, "R8 regrant");
    step('0, 1'b0, "R8 done");

    // lower stage pending, higher arrives later
    step(4'b1000, 1'b0, "R3 low");
    step(4'b0001, 1'b0, "R3 high");
    step('0, 1'b1, "R3 head");
    step('0, 1'b1, "R6 tail");
    step('0, 1'b0, "R6 quiet");

    // random requests with a processor stub that acknowledges at random
    for (int k = 0; k < 2000; k++) begin
      logic [N-1:0] r;
      logic a;
      r = (($urandom % 4) == 0) ? N'($urandom) : '0;
      a = cpu_irq ? (($urandom % 3) == 0) : (($urandom % 16) == 0);
      step(r, a, "rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule